// File: doc/BRIEF.md
# Page-Bounded Bus-Master Write DMA

This block copies a run of words arriving from a device into memory. It does this by becoming a bus master itself. Software loads a start byte address and a word count through a small register port, then sets a start bit. If the run fits inside one physical page, the engine raises a bus request and waits for the grant. It then writes one word per accepted bus cycle, moving the address on by one word after each. When the last word is taken it drops the request and sets a done flag. If the run does not fit in one page, or the count is zero, the engine sets an error flag at once and never requests the bus. The interrupt is a level: done OR error. Software clears each flag by writing 1 to it.

Device words arrive on a valid/ready stream. A word moves when both `dev_valid` and `dev_ready` are high at a rising edge. The engine raises `dev_ready` only while it owns the bus and the slave is not stalling, so slave wait applies back-pressure straight to the device. When the device has nothing valid, the engine keeps the bus and issues no write strobe until a word shows up. Data goes from the device pins to the bus pins with no register stage in between.

Top module: `dma_wr_engine`

## Requirements
- R1: After reset, `bus_req`, `bus_we`, `dev_ready` and `irq` are low, and the status register reads 0.
- R2: The register map is as follows. Offset 0 holds the start byte address; its low two bits read as zero. Offset 1 holds the word count. Writing offset 2 with bit 0 set is a start. Offset 3 is status: bit 0 busy, bit 1 done, bit 2 error. A valid start raises `bus_req` in the following cycle. `bus_we` stays low until `bus_gnt` has been seen.
- R3: The n-th accepted word (n from 0) goes out with `bus_addr` = start + 4n and `bus_wdata` equal to the n-th device word. A word is accepted at an edge where `bus_we` is high and `bus_wait` is low. The address never leaves the start page while `bus_req` is held.
- R4: While `bus_wait` is high, `dev_ready` is low, and `bus_addr` is held in the next cycle.
- R5: While `dev_valid` is low, `bus_we` is low, and an owned bus stays requested.
- R6: In the cycle after the last word is accepted, `bus_req` is low, status reads done=1 and busy=0, and `irq` is high.
- R7: A start is rejected when the count is zero or when (word offset in page + count) exceeds the page size in words. A rejected start sets error=1 and raises `irq`, and `bus_req` stays low.
- R8: Writing status with bit 1 set clears done. Writing status with bit 2 set clears error. `irq` falls only when both are clear.
- R9: `irq` never rises while `bus_req` is high, so there is no per-word interrupt.
- R10: A start written while busy is ignored, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data (combinational on cfg_addr) |
| dev_valid | input | 1 | Device word valid |
| dev_ready | output | 1 | Engine can take a device word |
| dev_data | input | DW | Device word |
| bus_req | output | 1 | Bus request, held for the whole transfer |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_addr | output | AW | Write byte address |
| bus_wdata | output | DW | Write data |
| bus_we | output | 1 | Write strobe |
| bus_wait | input | 1 | Slave stall |
| irq | output | 1 | Done or error pending |

## Verification
The hardest case to reach is the one where slave stalls and device gaps overlap. There the address must freeze, and the write strobe must vanish while the request stays up. The bench drives a slave wait on one fixed phase of a cycle counter and device gaps on a phase of a different period. Over a long run the two patterns drift past each other, so every mix of the two occurs. A grant latency of several cycles keeps a second start inside the request phase, and runs that end exactly on the last word of a page test the page rule from both sides.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } dma_state_e;

  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_CNT  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int BIT_BUSY = 0;
  localparam int BIT_DONE = 1;
  localparam int BIT_ERR  = 2;
endpackage

// File: rtl/dma_page_check.sv
module dma_page_check #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int CW         = 11
) (
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  output logic          fits
);
  localparam int PB  = $clog2(PAGE_BYTES);
  localparam int OW  = PB - 2;
  localparam int WPP = PAGE_BYTES / 4;

  logic [CW:0] span;

  always_comb begin
    span = {{(CW + 1 - OW){1'b0}}, start_addr[PB-1:2]} + {1'b0, word_cnt};
    fits = (word_cnt != '0) && (span <= (CW + 1)'(WPP));
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          finish,
  input  logic          fits,
  output logic [AW-1:0] start_addr,
  output logic [CW-1:0] word_cnt,
  output logic          go,
  output logic          irq
);
  logic done_q, err_q;
  logic wr_ctrl, wr_stat, start_req, reject;

  always_comb begin
    wr_ctrl   = cfg_wr && (cfg_addr == OFS_CTRL);
    wr_stat   = cfg_wr && (cfg_addr == OFS_STAT);
    start_req = wr_ctrl && cfg_wdata[0] && !busy;
    go        = start_req && fits;
    reject    = start_req && !fits;
    irq       = done_q || err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      word_cnt   <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == OFS_ADDR) start_addr <= {cfg_wdata[AW-1:2], 2'b00};
      if (cfg_addr == OFS_CNT)  word_cnt   <= cfg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (finish)                               done_q <= 1'b1;
      else if (wr_stat && cfg_wdata[BIT_DONE])  done_q <= 1'b0;
      if (reject)                               err_q  <= 1'b1;
      else if (wr_stat && cfg_wdata[BIT_ERR])   err_q  <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_ADDR: cfg_rdata = start_addr;
      OFS_CNT:  cfg_rdata = {{(AW - CW){1'b0}}, word_cnt};
      OFS_CTRL: cfg_rdata = '0;
      OFS_STAT: begin
        cfg_rdata[BIT_BUSY] = busy;
        cfg_rdata[BIT_DONE] = done_q;
        cfg_rdata[BIT_ERR]  = err_q;
      end
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          bus_gnt,
  input  logic          bus_wait,
  input  logic          dev_valid,
  input  logic [DW-1:0] dev_data,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          dev_ready,
  output logic          busy,
  output logic          finish
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  dma_state_e    state;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain;
  logic          in_xfer, accept;

  always_comb begin
    in_xfer   = (state == ST_XFER);
    dev_ready = in_xfer && !bus_wait;
    bus_we    = in_xfer && dev_valid;
    accept    = bus_we && !bus_wait;
    finish    = accept && (remain == CW'(1));
    bus_req   = (state != ST_IDLE);
    busy      = bus_req;
    bus_addr  = cur_addr;
    bus_wdata = dev_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          cur_addr <= start_addr;
          remain   <= word_cnt;
          state    <= ST_REQ;
        end
        ST_REQ: if (bus_gnt) state <= ST_XFER;
        ST_XFER: if (accept) begin
          cur_addr <= cur_addr + STEP;
          remain   <= remain - CW'(1);
          if (remain == CW'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_wr_engine.sv
module dma_wr_engine #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          dev_valid,
  output logic          dev_ready,
  input  logic [DW-1:0] dev_data,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  input  logic          bus_wait,
  output logic          irq
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int CW = PB - 1;

  logic [AW-1:0] start_addr;
  logic [CW-1:0] word_cnt;
  logic          go, busy, finish, fits;

  dma_page_check #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .CW(CW)) u_page (
    .start_addr (start_addr),
    .word_cnt   (word_cnt),
    .fits       (fits)
  );

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .busy       (busy),
    .finish     (finish),
    .fits       (fits),
    .start_addr (start_addr),
    .word_cnt   (word_cnt),
    .go         (go),
    .irq        (irq)
  );

  dma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .start_addr (start_addr),
    .word_cnt   (word_cnt),
    .bus_gnt    (bus_gnt),
    .bus_wait   (bus_wait),
    .dev_valid  (dev_valid),
    .dev_data   (dev_data),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .dev_ready  (dev_ready),
    .busy       (busy),
    .finish     (finish)
  );
endmodule

// File: rtl/dma_wr_engine_chk.sv
module dma_wr_engine_chk #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_valid,
  input logic          dev_ready,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          bus_wait,
  input logic          irq
);
  localparam int PB = $clog2(PAGE_BYTES);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_we && !bus_wait)) |=> bus_req); // R2
  AST_WE_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_req && bus_gnt)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_wait) |=> (!bus_req || bus_addr == $past(bus_addr) + AW'(4))); // R3
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> (bus_addr[AW-1:PB] == $past(bus_addr[AW-1:PB]))); // R3
  AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> !dev_ready); // R4
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wait) |=> $stable(bus_addr)); // R4
  AST_NO_WE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_valid |-> !bus_we); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req); // R9
endmodule

bind dma_wr_engine dma_wr_engine_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_valid (dev_valid),
  .dev_ready (dev_ready),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wait  (bus_wait),
  .irq       (irq)
);

// File: tb/dma_wr_engine_tb.sv
module dma_wr_engine_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          dev_valid = 1'b0;
  logic          dev_ready;
  logic [DW-1:0] dev_data = '0;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we;
  logic          bus_wait = 1'b0;
  logic          irq;

  always #5 clk = ~clk;

  dma_wr_engine #(.AW(AW), .DW(DW), .PAGE_BYTES(4096)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .dev_data(dev_data), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_wait(bus_wait), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [AW-1:0] exp_addr_q[$];
  logic [DW-1:0] exp_data_q[$];
  logic [DW-1:0] dev_q[$];
  bit  gap_en = 0, wait_en = 0;
  int  gnt_lat = 2;
  int  cyc = 0, gcnt = 0;
  bit  fire = 0, last_pending = 0, prev_wait = 0, irq_prev = 0;
  logic [AW-1:0] wait_addr = '0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, logic [AW-1:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(logic [1:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // environment: device source, slave wait pattern, arbiter with latency
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (fire && dev_q.size() > 0) void'(dev_q.pop_front());
      dev_valid = (dev_q.size() > 0) && !(gap_en && (cyc % 3 == 1));
      dev_data  = (dev_q.size() > 0) ? dev_q[0] : '0;
      bus_wait  = wait_en && (cyc % 4 == 2);
      if (bus_req === 1'b1) begin
        gcnt++;
        bus_gnt = (gcnt >= gnt_lat);
      end else begin
        gcnt = 0;
        bus_gnt = 1'b0;
      end
    end
  end

  // monitor: scoreboard pop/compare plus per-cycle protocol checks
  initial begin
    forever begin
      @(negedge clk);
      fire = dev_valid && dev_ready;
      if (rst_n) begin
        if (last_pending) begin
          check("R6 bus_req after last word", 64'(bus_req), 64'd0);
          check("R6 irq after last word", 64'(irq), 64'd1);
          last_pending = 0;
        end
        if (prev_wait) check("R4 addr held in wait", 64'(bus_addr), 64'(wait_addr));
        if (bus_req && bus_wait) check("R4 dev_ready in wait", 64'(dev_ready), 64'd0);
        prev_wait = bus_req && bus_wait;
        wait_addr = bus_addr;
        if (bus_req && bus_gnt && !dev_valid) begin
          check("R5 no strobe without data", 64'(bus_we), 64'd0);
          check("R5 bus kept", 64'(bus_req), 64'd1);
        end
        if (bus_we && !bus_wait) begin
          if (exp_addr_q.size() == 0) begin
            check("R3 unexpected write", 64'(bus_addr), 64'hFFFF_FFFF_FFFF_FFFF);
          end else begin
            check("R3 address", 64'(bus_addr), 64'(exp_addr_q.pop_front()));
            check("R3 data", 64'(bus_wdata), 64'(exp_data_q.pop_front()));
            if (exp_addr_q.size() == 0) last_pending = 1;
          end
        end
        if (irq && !irq_prev) check("R9 irq rise with bus idle", 64'(bus_req), 64'd0);
        irq_prev = irq;
      end
    end
  end

  task automatic run_xfer(logic [AW-1:0] start, int n, bit gap, bit wt, int lat, bit retry);
    logic [AW-1:0] rd;
    int guard;
    gap_en = gap; wait_en = wt; gnt_lat = lat;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w;
      w = $urandom;
      dev_q.push_back(w);
      exp_data_q.push_back(w);
      exp_addr_q.push_back(start + AW'(4 * i));
    end
    cfg_write(2'd0, start);
    cfg_write(2'd1, AW'(n));
    cfg_write(2'd2, 1);
    @(negedge clk);
    check("R2 req after start", 64'(bus_req), 64'd1);
    check("R2 no strobe before grant", 64'(bus_we), 64'd0);
    if (retry) begin
      cfg_write(2'd0, 32'h00AB_0000);
      cfg_write(2'd2, 1);
      cfg_read(2'd3, rd);
      check("R10 still busy", 64'(rd[2:0]), 64'b001);
    end
    guard = 0;
    while ((exp_addr_q.size() != 0 || bus_req) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    cfg_read(2'd3, rd);
    check("R6 status done", 64'(rd[2:0]), 64'b010);
    check("R6 irq", 64'(irq), 64'd1);
    cfg_write(2'd3, 32'h2);
    cfg_read(2'd3, rd);
    check("R8 done cleared", 64'(rd[2:0]), 64'b000);
    check("R8 irq low", 64'(irq), 64'd0);
  endtask

  task automatic try_reject(logic [AW-1:0] start, int n);
    logic [AW-1:0] rd;
    cfg_write(2'd0, start);
    cfg_write(2'd1, AW'(n));
    cfg_write(2'd2, 1);
    @(negedge clk);
    check("R7 no request", 64'(bus_req), 64'd0);
    check("R7 irq", 64'(irq), 64'd1);
    cfg_read(2'd3, rd);
    check("R7 status error", 64'(rd[2:0]), 64'b100);
    repeat (4) @(negedge clk);
    check("R7 still no request", 64'(bus_req), 64'd0);
    cfg_write(2'd3, 32'h2);
    @(negedge clk);
    check("R8 done-only clear keeps irq", 64'(irq), 64'd1);
    cfg_write(2'd3, 32'h4);
    cfg_read(2'd3, rd);
    check("R8 error cleared", 64'(rd[2:0]), 64'b000);
    check("R8 irq low after error clear", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] rd;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus_req", 64'(bus_req), 64'd0);
    check("R1 bus_we", 64'(bus_we), 64'd0);
    check("R1 dev_ready", 64'(dev_ready), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    cfg_read(2'd3, rd);
    check("R1 status", 64'(rd), 64'd0);

    run_xfer(32'h0000_1000, 8, 0, 0, 2, 0);
    run_xfer(32'h0002_0100, 12, 1, 0, 3, 0);
    run_xfer(32'h0003_0040, 10, 0, 1, 2, 0);
    run_xfer(32'h0004_0FF8, 2, 1, 1, 2, 0);
    run_xfer(32'h0005_0000, 1024, 1, 1, 4, 0);
    try_reject(32'h0006_0FF8, 3);
    try_reject(32'h0007_0000, 0);
    try_reject(32'h0008_0000, 1025);
    run_xfer(32'h0009_0200, 6, 0, 1, 20, 1);

    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule